// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a synchronous three-wire stereo PCM stream into parallel samples. The stream has a word-select line, a data line carrying two's-complement words MSB first, and a bit clock. The bit clock is either taken from a pin or made inside the block by dividing the master clock. The block's own clock is the master clock. The word-select, data and bit-clock inputs must be synchronous to it. All three inputs pass through one register stage before any logic uses them.

A build-time parameter picks one of three framings: I2S, left-justified, or right-justified with 16 bits. A second parameter gives the master-clock to word-select ratio. From these two parameters the block derives the number of bit slots per frame and the divide factor of its internal bit clock. Once per stereo frame, after the right word is complete, both samples appear together, left-aligned in 24 bits. A one-cycle strobe marks them. A frame-error pulse reports half-frames that carry the wrong number of bit clocks.

Top module: `pcm_serial_rx`

## Requirements
- R1: Data bits are taken on rising bit-clock edges, MSB first, and appear unchanged as two's-complement values on the sample outputs.
- R2: In I2S framing (format code 0), word-select low marks the left channel. The MSB sits in the second bit slot after a word-select transition, and a word's trailing bit may fall in the first slot of the next half-frame.
- R3: In left-justified framing (format code 1), word-select high marks the left channel and the MSB sits in the first bit slot after a transition.
- R4: In right-justified framing (format code 2), word-select high marks the left channel. The word is the last 16 bit slots before the closing transition, it lands on output bits [23:8], and earlier slots are ignored.
- R5: Words shorter than 24 bits are left-aligned and their missing LSBs read as zero. Bits after the 24th slot of a word are ignored.
- R6: With the external-clock select low, the bit clock is the master clock divided by N = ratio / slots-per-frame. Slots per frame are 72 for a ratio of 1152, 48 for ratios divisible by 3, and otherwise 64 for left-justified and 32 for the other two formats. Each bit is taken at the middle of its slot, and every word-select transition restarts the divider.
- R7: With the external-clock select high, bits are taken on rising edges of the bit-clock pin, and any number of slots of at least 16 per half-frame is accepted.
- R8: The valid output pulses for exactly one cycle per stereo frame, after the right word is complete. Both samples of that frame are updated together, and the sample outputs hold their values between pulses.
- R9: The frame-error output pulses for one cycle after a word-select transition in either of two cases: the half-frame that just ended had fewer than 16 bit clocks, or, with the internal clock, a count other than half the slots per frame. The first transition after reset never raises it.
- R10: While and right after reset, both sample outputs are zero and valid and frame-error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all logic runs on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_bclk_sel_i | input | 1 | 1: use the bit-clock pin, 0: use the internal divider |
| bclk_i | input | 1 | External bit clock, synchronous to clk_i |
| lrck_i | input | 1 | Word select, one period per stereo frame |
| sdata_i | input | 1 | Serial two's-complement data, MSB first |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is on the outputs |
| frame_err_o | output | 1 | One-cycle pulse for a half-frame with a bad bit-clock count |

## Verification
The bench builds three copies that share one serial bus. The first is I2S at ratio 256 (divide by 8, 16 slots per half-frame), so a 16-bit word spills its last bit across the word-select edge. The second is left-justified at ratio 384 (48 slots, divide by 8), which carries full 24-bit words and is also driven from the external clock with 32 slots per half-frame. The third is right-justified at ratio 128 (divide by 4), which exercises the smallest divider in use and padding slots set to ones. Together these sets reach every framing, two divider values, both clock sources, and short half-frames with both error rules.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ16 = 2'd2
  } pcm_fmt_e;

  localparam int OUT_W          = 24;
  localparam int RJ_BITS        = 16;
  localparam int MIN_HALF_TICKS = 16;
  localparam int IDX_W          = 7;

  // Bit slots per stereo frame for the internal bit clock.
  function automatic int slots_per_frame(input pcm_fmt_e fmt, input int ratio);
    if (ratio == 1152)  return 72;
    if (ratio % 3 == 0) return 48;
    if (fmt == FMT_LJ)  return 64;
    return 32;
  endfunction

endpackage

// File: rtl/pcm_rx_bitclk.sv
module pcm_rx_bitclk
  import pcm_rx_pkg::*;
#(
  parameter int DIV     = 8,
  parameter int CNT_W   = IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sel,
  input  logic             bclk_pin,
  input  logic             lrck_pin,
  input  logic             sdata_pin,
  output logic             tick,
  output logic             bit_val,
  output logic             lrck_lvl,
  output logic             lrck_edge,
  output logic [CNT_W-1:0] bit_idx
);

  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] MID_P  = PH_W'(DIV / 2);
  localparam logic [PH_W-1:0] LAST_P = PH_W'(DIV - 1);

  logic lrck_q, lrck_qq, sd_q, bclk_q, bclk_qq;
  logic [PH_W-1:0] ph, phase_now;
  logic int_tick, ext_tick;

  // Input register stage, all inputs share the master clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      lrck_q  <= 1'b0;
      lrck_qq <= 1'b0;
      sd_q    <= 1'b0;
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
    end else begin
      lrck_q  <= lrck_pin;
      lrck_qq <= lrck_q;
      sd_q    <= sdata_pin;
      bclk_q  <= bclk_pin;
      bclk_qq <= bclk_q;
    end
  end

  assign lrck_edge = lrck_q ^ lrck_qq;
  assign lrck_lvl  = lrck_q;
  assign bit_val   = sd_q;

  // Internal divider: phase 0 is the cycle a word-select change is seen.
  assign phase_now = lrck_edge ? '0 : ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= (phase_now == LAST_P) ? '0 : phase_now + 1'b1;
  end

  assign int_tick = (phase_now == MID_P);
  assign ext_tick = bclk_q & ~bclk_qq;
  assign tick     = ext_sel ? ext_tick : int_tick;

  // Slot counter within the current half-frame, saturating.
  always_ff @(posedge clk) begin
    if (rst)                          bit_idx <= '0;
    else if (lrck_edge)               bit_idx <= '0;
    else if (tick && (bit_idx != '1)) bit_idx <= bit_idx + 1'b1;
  end

  // R6 R7: a bit clock, internal or external, never ticks twice in a row.
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick)
    else $error("bit tick on consecutive cycles");

endmodule

// File: rtl/pcm_rx_deframe.sv
module pcm_rx_deframe
  import pcm_rx_pkg::*;
#(
  parameter pcm_fmt_e FORMAT    = FMT_I2S,
  parameter int       WORD_BITS = 24,
  parameter int       CNT_W     = IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             bit_val,
  input  logic             lrck_lvl,
  input  logic             lrck_edge,
  input  logic [CNT_W-1:0] bit_idx,
  output logic [OUT_W-1:0] smp_l,
  output logic [OUT_W-1:0] smp_r,
  output logic             smp_vld
);

  localparam int W = (FORMAT == FMT_RJ16) ? RJ_BITS : WORD_BITS;

  logic left_now;
  assign left_now = (FORMAT == FMT_I2S) ? ~lrck_lvl : lrck_lvl;

  generate
    if (FORMAT == FMT_RJ16) begin : g_rj
      // Right-justified: keep the newest W bits, commit on word-select change.
      logic [W-1:0] sr;
      logic         armed;

      always_ff @(posedge clk) begin
        if (rst) begin
          sr      <= '0;
          armed   <= 1'b0;
          smp_l   <= '0;
          smp_r   <= '0;
          smp_vld <= 1'b0;
        end else begin
          smp_vld <= 1'b0;
          if (tick) sr <= {sr[W-2:0], bit_val};
          if (lrck_edge) begin
            armed <= 1'b1;
            if (armed) begin
              if (!left_now) smp_l <= {sr, {(OUT_W-W){1'b0}}};
              else begin
                smp_r   <= {sr, {(OUT_W-W){1'b0}}};
                smp_vld <= 1'b1;
              end
            end
          end
        end
      end

      // R4: a right-justified pair is committed only at a word-select change.
      assert_rj_commit_edge_R4: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> ($past(lrck_edge) && (bit_idx == '0)))
        else $error("right-justified commit away from word-select change");

    end else begin : g_msb_first
      // I2S and left-justified: word starts at a fixed slot, fills MSB down.
      localparam int CW = $clog2(W + 1);
      localparam logic [CNT_W-1:0] START_IDX = (FORMAT == FMT_I2S) ? CNT_W'(1) : '0;
      localparam logic [CW-1:0]    W_C       = CW'(W);

      logic [OUT_W-1:0] acc;
      logic [CW-1:0]    cnt;
      logic             wch_left;
      logic             have_word;

      always_ff @(posedge clk) begin
        if (rst) begin
          acc       <= '0;
          cnt       <= '0;
          wch_left  <= 1'b0;
          have_word <= 1'b0;
          smp_l     <= '0;
          smp_r     <= '0;
          smp_vld   <= 1'b0;
        end else begin
          smp_vld <= 1'b0;
          if (tick) begin
            if (bit_idx == START_IDX) begin
              if (have_word) begin
                if (wch_left) smp_l <= acc;
                else begin
                  smp_r   <= acc;
                  smp_vld <= 1'b1;
                end
              end
              acc       <= {bit_val, {(OUT_W-1){1'b0}}};
              cnt       <= CW'(1);
              wch_left  <= left_now;
              have_word <= 1'b1;
            end else if (cnt < W_C) begin
              acc <= acc | ({bit_val, {(OUT_W-1){1'b0}}} >> cnt);
              cnt <= cnt + 1'b1;
            end
          end
        end
      end

      // R8: a pair is committed only on a bit tick, never on a word-select change.
      assert_commit_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> ($past(tick) && !$past(lrck_edge)))
        else $error("MSB-first commit without a bit tick");
    end
  endgenerate

endmodule

// File: rtl/pcm_rx_framechk.sv
module pcm_rx_framechk
  import pcm_rx_pkg::*;
#(
  parameter int HALF  = 16,
  parameter int CNT_W = IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_sel,
  input  logic             lrck_edge,
  input  logic [CNT_W-1:0] bit_idx,
  output logic             frame_err
);

  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_HALF_TICKS);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

  logic armed;
  logic bad_count;

  assign bad_count = (bit_idx < MIN_C) || (!ext_sel && (bit_idx != HALF_C));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= armed && lrck_edge && bad_count;
      if (lrck_edge) armed <= 1'b1;
    end
  end

  // R9: an error report always follows a word-select change.
  assert_err_after_edge_R9: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> $past(lrck_edge))
    else $error("frame error without a word-select change");

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter pcm_fmt_e FORMAT     = FMT_I2S,
  parameter int       MCLK_RATIO = 256,
  parameter int       WORD_BITS  = 24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ext_bclk_sel_i,
  input  logic              bclk_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  output logic [OUT_W-1:0]  left_o,
  output logic [OUT_W-1:0]  right_o,
  output logic              valid_o,
  output logic              frame_err_o
);

  localparam int SPF  = slots_per_frame(FORMAT, MCLK_RATIO);
  localparam int DIV  = MCLK_RATIO / SPF;
  localparam int HALF = SPF / 2;

  logic             tick, bit_val, lrck_lvl, lrck_edge;
  logic [IDX_W-1:0] bit_idx;
  logic [OUT_W-1:0] smp_l, smp_r;
  logic             smp_vld, frame_err;

  pcm_rx_bitclk #(.DIV(DIV), .CNT_W(IDX_W)) u_bitclk (
    .clk       (clk_i),
    .rst       (rst_i),
    .ext_sel   (ext_bclk_sel_i),
    .bclk_pin  (bclk_i),
    .lrck_pin  (lrck_i),
    .sdata_pin (sdata_i),
    .tick      (tick),
    .bit_val   (bit_val),
    .lrck_lvl  (lrck_lvl),
    .lrck_edge (lrck_edge),
    .bit_idx   (bit_idx)
  );

  pcm_rx_deframe #(.FORMAT(FORMAT), .WORD_BITS(WORD_BITS), .CNT_W(IDX_W)) u_deframe (
    .clk       (clk_i),
    .rst       (rst_i),
    .tick      (tick),
    .bit_val   (bit_val),
    .lrck_lvl  (lrck_lvl),
    .lrck_edge (lrck_edge),
    .bit_idx   (bit_idx),
    .smp_l     (smp_l),
    .smp_r     (smp_r),
    .smp_vld   (smp_vld)
  );

  pcm_rx_framechk #(.HALF(HALF), .CNT_W(IDX_W)) u_framechk (
    .clk       (clk_i),
    .rst       (rst_i),
    .ext_sel   (ext_bclk_sel_i),
    .lrck_edge (lrck_edge),
    .bit_idx   (bit_idx),
    .frame_err (frame_err)
  );

  // Registered outputs; the pair is latched only on a completed frame.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= smp_vld;
      frame_err_o <= frame_err;
      if (smp_vld) begin
        left_o  <= smp_l;
        right_o <= smp_r;
      end
    end
  end

  // R8: the strobe is a single-cycle pulse.
  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o)
    else $error("valid held for more than one cycle");

  // R8: samples hold between strobes.
  assert_samples_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> ($stable(left_o) && $stable(right_o)))
    else $error("sample outputs changed without a strobe");

endmodule

// File: tb/pcm_serial_rx_tb_top.sv
module pcm_serial_rx_tb_top;
  import pcm_rx_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst = 1'b1;
  logic ext_sel = 1'b0, bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;

  logic [23:0] l_o [3];
  logic [23:0] r_o [3];
  logic        v_o [3];
  logic        e_o [3];

  pcm_serial_rx #(.FORMAT(FMT_I2S), .MCLK_RATIO(256)) dut_i (
    .clk_i(clk), .rst_i(rst), .ext_bclk_sel_i(ext_sel), .bclk_i(bclk),
    .lrck_i(lrck), .sdata_i(sdata), .left_o(l_o[0]), .right_o(r_o[0]),
    .valid_o(v_o[0]), .frame_err_o(e_o[0]));

  pcm_serial_rx #(.FORMAT(FMT_LJ), .MCLK_RATIO(384)) dut_lj_i (
    .clk_i(clk), .rst_i(rst), .ext_bclk_sel_i(ext_sel), .bclk_i(bclk),
    .lrck_i(lrck), .sdata_i(sdata), .left_o(l_o[1]), .right_o(r_o[1]),
    .valid_o(v_o[1]), .frame_err_o(e_o[1]));

  pcm_serial_rx #(.FORMAT(FMT_RJ16), .MCLK_RATIO(128)) dut_rj_i (
    .clk_i(clk), .rst_i(rst), .ext_bclk_sel_i(ext_sel), .bclk_i(bclk),
    .lrck_i(lrck), .sdata_i(sdata), .left_o(l_o[2]), .right_o(r_o[2]),
    .valid_o(v_o[2]), .frame_err_o(e_o[2]));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Monitors sample at the falling edge, away from the active edge.
  logic [23:0] mon_l [3];
  logic [23:0] mon_r [3];
  int vcnt [3];
  int ecnt [3];

  initial begin
    for (int k = 0; k < 3; k++) begin
      mon_l[k] = '0; mon_r[k] = '0; vcnt[k] = 0; ecnt[k] = 0;
    end
  end

  always @(negedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (v_o[k]) begin
        mon_l[k] = l_o[k];
        mon_r[k] = r_o[k];
        vcnt[k]++;
      end
      if (e_o[k]) ecnt[k]++;
    end
  end

  task automatic check24(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Serial stream generator.
  logic [23:0] prev_w = '0;
  int          prev_half = 16;

  function automatic logic stream_bit(input int fmt, input logic [23:0] w, input int b,
                                      input int half);
    int idx;
    if (fmt == 0) begin
      if (b == 0) begin
        idx = prev_half - 1;
        return (idx < 24) ? prev_w[23-idx] : 1'b1;
      end
      idx = b - 1;
      return (idx < 24) ? w[23-idx] : 1'b1;
    end else if (fmt == 1) begin
      return (b < 24) ? w[23-b] : 1'b1;
    end
    if (b >= half - 16) return w[23-(b-(half-16))];
    return 1'b1;
  endfunction

  task automatic send_half(input int fmt, input logic [23:0] w, input bit side,
                           input int half, input int per, input bit ext);
    for (int b = 0; b < half; b++) begin
      if (b == 0) lrck = (fmt == 0) ? side : ~side;
      sdata = stream_bit(fmt, w, b, half);
      bclk  = 1'b0;
      repeat (per / 2) @(negedge clk);
      if (ext) bclk = 1'b1;
      repeat (per - per / 2) @(negedge clk);
    end
    prev_w    = w;
    prev_half = half;
  endtask

  task automatic send_frame(input int fmt, input logic [23:0] l, input logic [23:0] r,
                            input int half_l, input int half_r, input int per, input bit ext);
    ext_sel = ext;
    send_half(fmt, l, 1'b0, half_l, per, ext);
    send_half(fmt, r, 1'b1, half_r, per, ext);
  endtask

  function automatic int half_of(input int t);
    return (t == 1) ? 24 : 16;
  endfunction

  function automatic int per_of(input int t);
    return (t == 2) ? 4 : 8;
  endfunction

  function automatic logic [23:0] expect_word(input int t, input logic [23:0] w, input int half);
    if (t == 1) return (half >= 24) ? w : 24'h0;
    return {w[23:8], 8'h00};
  endfunction

  function automatic string tag_of(input int t);
    if (t == 0) return "R1 R2 R5 R6 I2S";
    if (t == 1) return "R1 R3 R6 left-justified";
    return "R1 R4 R5 R6 right-justified";
  endfunction

  // Vectors: {format target[1:0], left[23:0], right[23:0]}
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 24'h123456, 24'hFEDCBA},
    {2'd0, 24'h800000, 24'h7FFFFF},
    {2'd0, 24'hFFFFFF, 24'h000100},
    {2'd1, 24'hA5A5A5, 24'h5A5A5A},
    {2'd1, 24'h800001, 24'h7FFFFE},
    {2'd1, 24'h000001, 24'hFFFFFF},
    {2'd2, 24'hC3C3FF, 24'h00FF11},
    {2'd2, 24'h7FFF00, 24'h800000},
    {2'd1, 24'h000000, 24'h123457},
    {2'd0, 24'h00FF00, 24'hFF00FF}
  };

  initial begin
    int v0, e0;
    repeat (5) @(negedge clk);
    // R10: reset state on every copy.
    for (int k = 0; k < 3; k++) begin
      check24("R10 reset left", l_o[k], 24'h0);
      check24("R10 reset right", r_o[k], 24'h0);
      check_int("R10 reset valid", int'(v_o[k]), 0);
      check_int("R10 reset frame error", int'(e_o[k]), 0);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check_int("R10 valid low after reset", int'(v_o[k]), 0);
    end

    // Vector walk with the internal bit clock.
    for (int i = 0; i < NV; i++) begin
      int t;
      logic [23:0] lv, rv;
      t  = int'(VEC[i][49:48]);
      lv = VEC[i][47:24];
      rv = VEC[i][23:0];
      send_frame(t, 24'h0, 24'h0, half_of(t), half_of(t), per_of(t), 1'b0);
      send_frame(t, lv, rv, half_of(t), half_of(t), per_of(t), 1'b0);
      send_frame(t, 24'h0, 24'h0, half_of(t), half_of(t), per_of(t), 1'b0);
      check24({tag_of(t), " left"}, mon_l[t], expect_word(t, lv, half_of(t)));
      check24({tag_of(t), " right"}, mon_r[t], expect_word(t, rv, half_of(t)));
    end

    // R8 R9: three clean internal left-justified frames -> three strobes, no error.
    send_frame(1, 24'h0, 24'h0, 24, 24, 8, 1'b0);
    v0 = vcnt[1]; e0 = ecnt[1];
    send_frame(1, 24'h111111, 24'h222222, 24, 24, 8, 1'b0);
    send_frame(1, 24'h333333, 24'h444444, 24, 24, 8, 1'b0);
    send_frame(1, 24'h555555, 24'h666666, 24, 24, 8, 1'b0);
    check_int("R8 one strobe per frame", vcnt[1] - v0, 3);
    check_int("R9 no error on clean frames", ecnt[1] - e0, 0);
    check24("R8 pair left", mon_l[1], 24'h333333);
    check24("R8 pair right", mon_r[1], 24'h444444);

    // R9: internal half-frame with 20 slots instead of 24.
    e0 = ecnt[1];
    send_frame(1, 24'h0, 24'h0, 20, 24, 8, 1'b0);
    send_frame(1, 24'h0, 24'h0, 24, 24, 8, 1'b0);
    check_int("R9 internal wrong slot count", ecnt[1] - e0, 1);

    // R7 R5: external clock, 32 slots per half, trailing ones ignored.
    send_frame(1, 24'h0, 24'h0, 32, 32, 8, 1'b1);
    e0 = ecnt[1];
    send_frame(1, 24'h9ABCDE, 24'h13579B, 32, 32, 8, 1'b1);
    send_frame(1, 24'h0, 24'h0, 32, 32, 8, 1'b1);
    check24("R7 R5 external left-justified left", mon_l[1], 24'h9ABCDE);
    check24("R7 R5 external left-justified right", mon_r[1], 24'h13579B);
    check_int("R7 R9 external 32 slots accepted", ecnt[1] - e0, 0);

    // R9: external half-frame with only 12 bit clocks.
    e0 = ecnt[1];
    send_frame(1, 24'h0, 24'h0, 12, 32, 8, 1'b1);
    send_frame(1, 24'h0, 24'h0, 32, 32, 8, 1'b1);
    check_int("R9 external short half-frame", ecnt[1] - e0, 1);

    // R4 R7: right-justified, external clock, 32 slots with leading ones.
    send_frame(2, 24'h0, 24'h0, 32, 32, 8, 1'b1);
    send_frame(2, 24'hBEEF12, 24'h4321AB, 32, 32, 8, 1'b1);
    send_frame(2, 24'h0, 24'h0, 32, 32, 8, 1'b1);
    check24("R4 R7 external right-justified left", mon_l[2], 24'hBEEF00);
    check24("R4 R7 external right-justified right", mon_r[2], 24'h432100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule